// File: doc/BRIEF.md
# System Clock Source and Power-Mode Controller

This block produces the internal clock phase for a small processor and for its peripherals. It takes both oscillators as tick strobes on one reference clock. The fast main oscillator feeds a middle-speed and a high-speed ratio. The slow sub oscillator feeds a low-speed ratio. A three-bit mode register chooses the source and the main division ratio, and it can halt the main oscillator once the sub source is in use. Each oscillator has its own settle counter, which drives a stable flag.

Two low-power modes are available. In the idle mode the oscillators keep running and only the processor phase is frozen high. In the halt mode both oscillators are switched off and both phases are frozen high. Either mode ends on reset or on a wake-up interrupt. Leaving the halt mode restarts the oscillators, and the processor phase stays frozen until the selected source reports stable again.

Source changes, ratio changes and entry into either low-power mode all wait for a rising edge of the internal phase. Because of this, no output ever carries a shortened pulse.

Top module: `sysclk_pmc`

## Requirements
- R1: After reset the mode register reads 000 (main source, middle speed, main running) and both oscillator enables are high. Both phases are held high until the main stable flag rises; the block then runs.
- R2: With mode bits 7/6 = 0/0, each phase period is MID_DIV main ticks, high for half of them.
- R3: With bit 6 = 1 and bit 7 = 0, the period is HIGH_DIV main ticks.
- R4: With bit 7 = 1, the period is LOW_DIV sub ticks, regardless of bit 6.
- R5: Bit 5 = 1 turns the main oscillator enable off only while the sub source is the applied source; the sub-driven phase keeps running.
- R6: A write with bit 7 = 0 leaves bit 7 unchanged when bit 5 was already set or is being set by the same write. Bits 6 and 5 still take the written values.
- R7: A new source or ratio is applied only at a rising edge of the internal phase, so no low or high phase is shorter than one source tick period.
- R8: In the halt mode both oscillator enables are low, and both phase outputs are high.
- R9: In the idle mode the oscillators stay enabled and the peripheral phase keeps toggling, while the processor phase stays high.
- R10: A wake pulse moves the idle mode back to run, and the processor phase resumes at the next phase rise. A wake pulse in the halt mode re-enables the oscillators on the next cycle and keeps the processor phase high until the selected source is stable.
- R11: A stable flag rises after MAIN_SETTLE (main) or SUB_SETTLE (sub) ticks of an enabled oscillator. It drops one cycle after its enable falls. After a wake from the halt mode, the sub flag is still low when the main flag rises.
- R12: Idle and halt requests are held pending and take effect at the next rising edge of the internal phase, so the processor phase never ends a low phase early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state is clocked on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | One-cycle strobe per main oscillator cycle |
| sub_tick | input | 1 | One-cycle strobe per sub oscillator cycle |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 3 ([7:5]) | Written mode bits: 7 source (1 = sub), 6 ratio (1 = high speed), 5 main halt |
| stop_req | input | 1 | Request for the halt mode (oscillators off) |
| wait_req | input | 1 | Request for the idle mode (processor phase frozen) |
| wake_irq | input | 1 | Wake-up interrupt pulse |
| phi_cpu | output | 1 | Processor clock phase |
| phi_per | output | 1 | Peripheral clock phase |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| main_stable | output | 1 | Main oscillator settled |
| sub_stable | output | 1 | Sub oscillator settled |
| cfg_state | output | 3 ([7:5]) | Current mode register bits |

## Verification
A wrong power state shows up at once as a processor phase that keeps toggling when it should be frozen, or as an oscillator enable that stays high in the halt mode. Either error is visible within one phase period of the request. A wrong applied configuration shows up in the next full phase period as a wrong period length or a shortened phase. A settle counter that restarts wrongly, or never restarts, shows up as a phase that resumes too early or too late after wake, and as a stable flag seen at the wrong cycle. A mode register that accepts a forbidden write is visible directly on cfg_state in the cycle after the write.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef enum logic [1:0] {
    PM_WARM = 2'd0,
    PM_RUN  = 2'd1,
    PM_WAIT = 2'd2,
    PM_STOP = 2'd3
  } pm_state_e;

  // Mode register image, msb first: source, ratio, main halt (bits 7..5).
  typedef struct packed {
    logic src_sub;
    logic div_fast;
    logic main_halt;
  } clk_cfg_t;

  // Source ticks per phase half for the given selection.
  function automatic int unsigned phase_ticks(input logic src_sub, input logic div_fast,
                                              input int unsigned mid_div,
                                              input int unsigned high_div,
                                              input int unsigned low_div);
    if (src_sub) return low_div / 2;
    if (div_fast) return high_div / 2;
    return mid_div / 2;
  endfunction

  // Register update: returning to the main source is refused while a main halt
  // is stored or being written.
  function automatic clk_cfg_t cfg_merge(input clk_cfg_t cur, input logic [2:0] wd);
    clk_cfg_t nxt;
    nxt.div_fast  = wd[1];
    nxt.main_halt = wd[0];
    if (wd[2])                          nxt.src_sub = 1'b1;
    else if (cur.main_halt || wd[0])    nxt.src_sub = cur.src_sub;
    else                                nxt.src_sub = 1'b0;
    return nxt;
  endfunction

endpackage

// File: rtl/sysclk_osc_stab.sv
module sysclk_osc_stab #(
  parameter int unsigned SETTLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic stable
);
  localparam int unsigned CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (!en)                     cnt_q <= '0;
    else if (tick && cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign stable = (cnt_q == LIMIT);
endmodule

// File: rtl/sysclk_phase_div.sv
module sysclk_phase_div #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [CW-1:0] half_m1,
  output logic          phi,
  output logic          rise_evt
);
  logic [CW-1:0] cnt_q;
  logic          phi_q;
  logic          flip;

  assign flip     = tick && run && (cnt_q == half_m1);
  assign rise_evt = flip && !phi_q;
  assign phi      = phi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phi_q <= 1'b1;
    end else if (flip) begin
      cnt_q <= '0;
      phi_q <= ~phi_q;
    end else if (tick && run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sysclk_pmc.sv
module sysclk_pmc #(
  parameter int unsigned MID_DIV     = 8,
  parameter int unsigned HIGH_DIV    = 2,
  parameter int unsigned LOW_DIV     = 2,
  parameter int unsigned MAIN_SETTLE = 8,
  parameter int unsigned SUB_SETTLE  = 32
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       cfg_we,
  input  logic [7:5] cfg_wdata,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       wake_irq,
  output logic       phi_cpu,
  output logic       phi_per,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic       main_stable,
  output logic       sub_stable,
  output logic [7:5] cfg_state
);
  import sysclk_pkg::*;

  localparam int unsigned MAX_DIV =
    (MID_DIV > HIGH_DIV) ? ((MID_DIV > LOW_DIV) ? MID_DIV : LOW_DIV)
                         : ((HIGH_DIV > LOW_DIV) ? HIGH_DIV : LOW_DIV);
  localparam int unsigned HW = $clog2(MAX_DIV / 2 + 1);

  clk_cfg_t  cfg_q, act_q;
  pm_state_e pm_q;
  logic      stop_pend, wait_pend, cpu_hold;

  // Named internal events (observed by the checker).
  logic          main_tk, sub_tk, src_tick, src_stable, div_run;
  logic          rise_evt, cfg_apply, enter_stop, enter_wait, phi_int;
  logic [HW-1:0] half_m1;
  logic [7:5]    act_bits;

  assign main_osc_en = (pm_q != PM_STOP) && !(cfg_q.main_halt && act_q.src_sub);
  assign sub_osc_en  = (pm_q != PM_STOP);
  assign main_tk     = main_tick && main_osc_en;
  assign sub_tk      = sub_tick && sub_osc_en;
  assign src_tick    = act_q.src_sub ? sub_tk : main_tk;
  assign src_stable  = act_q.src_sub ? sub_stable : main_stable;
  assign div_run     = (pm_q == PM_RUN) || (pm_q == PM_WAIT);
  assign half_m1     = HW'(phase_ticks(act_q.src_sub, act_q.div_fast,
                                       MID_DIV, HIGH_DIV, LOW_DIV) - 1);
  assign cfg_apply   = rise_evt;
  assign enter_stop  = rise_evt && stop_pend && (pm_q == PM_RUN);
  assign enter_wait  = rise_evt && wait_pend && !stop_pend && (pm_q == PM_RUN);
  assign act_bits    = act_q;

  sysclk_osc_stab #(.SETTLE(MAIN_SETTLE)) u_main_stab (
    .clk(clk_ref), .rst_n(rst_n), .en(main_osc_en), .tick(main_tk), .stable(main_stable));

  sysclk_osc_stab #(.SETTLE(SUB_SETTLE)) u_sub_stab (
    .clk(clk_ref), .rst_n(rst_n), .en(sub_osc_en), .tick(sub_tk), .stable(sub_stable));

  sysclk_phase_div #(.CW(HW)) u_div (
    .clk(clk_ref), .rst_n(rst_n), .tick(src_tick), .run(div_run),
    .half_m1(half_m1), .phi(phi_int), .rise_evt(rise_evt));

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      act_q <= '0;
    end else begin
      if (cfg_we)    cfg_q <= cfg_merge(cfg_q, cfg_wdata);
      if (cfg_apply) act_q <= cfg_q;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pm_q      <= PM_WARM;
      stop_pend <= 1'b0;
      wait_pend <= 1'b0;
      cpu_hold  <= 1'b1;
    end else begin
      stop_pend <= (pm_q == PM_RUN) && !enter_stop && (stop_pend || stop_req);
      wait_pend <= (pm_q == PM_RUN) && !enter_stop && !enter_wait && (wait_pend || wait_req);
      if (enter_stop || enter_wait)         cpu_hold <= 1'b1;
      else if (rise_evt && pm_q == PM_RUN)  cpu_hold <= 1'b0;
      case (pm_q)
        PM_WARM: if (src_stable) pm_q <= PM_RUN;
        PM_RUN:  if (enter_stop) pm_q <= PM_STOP;
                 else if (enter_wait) pm_q <= PM_WAIT;
        PM_WAIT: if (wake_irq) pm_q <= PM_RUN;
        PM_STOP: if (wake_irq) pm_q <= PM_WARM;
        default: pm_q <= PM_WARM;
      endcase
    end
  end

  assign phi_per   = phi_int;
  assign phi_cpu   = phi_int | cpu_hold;
  assign cfg_state = cfg_q;
endmodule

// File: rtl/sysclk_pmc_chk.sv
module sysclk_pmc_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [1:0] pm_state,
  input logic       phi_cpu,
  input logic       phi_per,
  input logic       main_osc_en,
  input logic       sub_osc_en,
  input logic       main_stable,
  input logic       sub_stable,
  input logic [7:5] cfg_state,
  input logic [7:5] act_bits
);
  localparam logic [1:0] S_WARM = 2'd0, S_WAIT = 2'd2, S_STOP = 2'd3;

  a_r1_warm_holds: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pm_state == S_WARM |-> phi_cpu && phi_per);

  a_r5_main_off_needs_sub: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!main_osc_en && pm_state != S_STOP) |-> act_bits[7]);

  a_r6_no_main_while_halted: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(cfg_state[7]) |-> !$past(cfg_state[5]) && !cfg_state[5]);

  a_r7_apply_on_rise: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(act_bits) |-> $rose(phi_per));

  a_r8_stop_quiet: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pm_state == S_STOP |-> !main_osc_en && !sub_osc_en && phi_cpu && phi_per);

  a_r9_wait_cpu_high: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pm_state == S_WAIT |-> phi_cpu && sub_osc_en);

  a_r10_stop_exit_warm: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(pm_state) == S_STOP && pm_state != S_STOP) |-> pm_state == S_WARM);

  a_r11_main_flag_drop: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !main_osc_en |=> !main_stable);

  a_r11_sub_flag_drop: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !sub_osc_en |=> !sub_stable);
endmodule

bind sysclk_pmc sysclk_pmc_chk u_chk (
  .clk_ref     (clk_ref),
  .rst_n       (rst_n),
  .pm_state    (pm_q),
  .phi_cpu     (phi_cpu),
  .phi_per     (phi_per),
  .main_osc_en (main_osc_en),
  .sub_osc_en  (sub_osc_en),
  .main_stable (main_stable),
  .sub_stable  (sub_stable),
  .cfg_state   (cfg_state),
  .act_bits    (act_bits)
);

// File: tb/sysclk_pmc_tb.sv
module sysclk_pmc_tb;
  logic clk_ref = 1'b0, rst_n = 1'b0;
  logic main_tick = 1'b0, sub_tick = 1'b0, cfg_we = 1'b0;
  logic [7:5] cfg_wdata = '0;
  logic stop_req = 1'b0, wait_req = 1'b0, wake_irq = 1'b0;
  logic phi_cpu, phi_per, main_osc_en, sub_osc_en, main_stable, sub_stable;
  logic [7:5] cfg_state;

  int checks = 0, failures = 0, runts = 0, low_len = 0, tcnt = 0;
  // Main tick every 2 cycles, sub tick every 16 cycles.
  localparam int MID_PER = 16, HIGH_PER = 4, LOW_PER = 32;

  sysclk_pmc u_dut (.*);

  always #10 clk_ref = ~clk_ref;

  always @(negedge clk_ref) begin
    tcnt++;
    main_tick = (tcnt % 2 == 0);
    sub_tick  = (tcnt % 16 == 0);
  end

  // Shortened-low-phase monitor on the processor phase (R7, R12).
  always @(negedge clk_ref) begin
    if (rst_n) begin
      if (!phi_cpu) low_len++;
      else begin
        if (low_len > 0 && low_len < 2) runts++;
        low_len = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:5] v);
    @(negedge clk_ref); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk_ref); cfg_we = 1'b0;
  endtask

  task automatic pulse_wait(); @(negedge clk_ref); wait_req = 1'b1; @(negedge clk_ref); wait_req = 1'b0; endtask
  task automatic pulse_stop(); @(negedge clk_ref); stop_req = 1'b1; @(negedge clk_ref); stop_req = 1'b0; endtask
  task automatic pulse_wake(); @(negedge clk_ref); wake_irq = 1'b1; @(negedge clk_ref); wake_irq = 1'b0; endtask

  task automatic measure(output int per, output int hi);
    int guard = 0;
    bit prev;
    per = 0; hi = 0;
    prev = phi_cpu; @(negedge clk_ref);
    while (!(!prev && phi_cpu) && guard < 2000) begin prev = phi_cpu; @(negedge clk_ref); guard++; end
    do begin
      if (phi_cpu) hi++;
      per++; prev = phi_cpu; @(negedge clk_ref);
    end while (!(!prev && phi_cpu) && per < 2000);
  endtask

  task automatic t_reset();
    int guard = 0;
    bit held = 1'b1;
    chk(phi_cpu && phi_per, "R1 phases high after reset", phi_cpu, 1);
    chk(main_osc_en && sub_osc_en, "R1 enables after reset", {main_osc_en, sub_osc_en}, 3);
    chk(cfg_state == 3'b000, "R1 mode register reset", cfg_state, 0);
    while (!main_stable && guard < 200) begin
      if (!phi_cpu) held = 1'b0;
      @(negedge clk_ref); guard++;
    end
    chk(held, "R1 phase held until main stable", held, 1);
    chk(main_stable && !sub_stable, "R11 main settles before sub", sub_stable, 0);
  endtask

  task automatic t_mid();
    int per, hi;
    measure(per, hi);
    chk(per == MID_PER && hi == MID_PER / 2, "R2 middle-speed period", per, MID_PER);
  endtask

  task automatic t_high();
    int per, hi;
    cfg_write(3'b010);
    repeat (40) @(negedge clk_ref);
    measure(per, hi);
    chk(per == HIGH_PER && hi == HIGH_PER / 2, "R3 high-speed period", per, HIGH_PER);
  endtask

  task automatic t_switch();
    int len = 0, bad = 0;
    bit prev;
    // R7: around a ratio change every full phase is 2 or 8 cycles.
    cfg_write(3'b000);
    prev = phi_per;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk_ref);
      if (phi_per == prev) len++;
      else begin
        if (i > 1 && len + 1 != 2 && len + 1 != 8) bad++;
        len = 0; prev = phi_per;
      end
    end
    chk(bad == 0, "R7 no shortened phase on ratio change", bad, 0);
  endtask

  task automatic t_low();
    int per, hi, guard = 0;
    while (!sub_stable && guard < 2000) begin @(negedge clk_ref); guard++; end
    chk(sub_stable, "R11 sub stable after settle", sub_stable, 1);
    cfg_write(3'b110);
    repeat (100) @(negedge clk_ref);
    measure(per, hi);
    chk(per == LOW_PER && hi == LOW_PER / 2, "R4 low-speed period", per, LOW_PER);
  endtask

  task automatic t_halt();
    int per, hi;
    cfg_write(3'b101);
    repeat (3) @(negedge clk_ref);
    chk(!main_osc_en, "R5 main enable off under sub source", main_osc_en, 0);
    chk(!main_stable, "R11 main flag drops with enable", main_stable, 0);
    measure(per, hi);
    chk(per == LOW_PER, "R5 sub phase unaffected by halt", per, LOW_PER);
  endtask

  task automatic t_guard();
    int per, hi, guard = 0;
    cfg_write(3'b001);
    chk(cfg_state == 3'b101, "R6 source clear refused while halted", cfg_state, 3'b101);
    measure(per, hi);
    chk(per == LOW_PER, "R6 refused write keeps low speed", per, LOW_PER);
    cfg_write(3'b100);
    repeat (2) @(negedge clk_ref);
    chk(main_osc_en, "R5 main enable back after halt clear", main_osc_en, 1);
    while (!main_stable && guard < 200) begin @(negedge clk_ref); guard++; end
    cfg_write(3'b000);
    chk(cfg_state == 3'b000, "R6 source clear accepted when running", cfg_state, 0);
    repeat (100) @(negedge clk_ref);
    measure(per, hi);
    chk(per == MID_PER, "R2 middle speed restored", per, MID_PER);
  endtask

  task automatic t_wait();
    int toggles = 0;
    bit cpu_high = 1'b1, prev, seen_low = 1'b0;
    pulse_wait();
    repeat (40) @(negedge clk_ref);
    prev = phi_per;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_ref);
      if (!phi_cpu) cpu_high = 1'b0;
      if (phi_per != prev) toggles++;
      prev = phi_per;
    end
    chk(cpu_high, "R9 processor phase high in idle", cpu_high, 1);
    chk(toggles >= 6, "R9 peripheral phase toggles in idle", toggles, 8);
    chk(main_osc_en && sub_osc_en, "R9 oscillators run in idle", {main_osc_en, sub_osc_en}, 3);
    pulse_wake();
    for (int i = 0; i < 40; i++) begin @(negedge clk_ref); if (!phi_cpu) seen_low = 1'b1; end
    chk(seen_low, "R10 processor phase resumes after idle wake", seen_low, 1);
  endtask

  task automatic t_stop();
    int per, hi, guard = 0;
    bit high = 1'b1;
    pulse_stop();
    repeat (40) @(negedge clk_ref);
    chk(!main_osc_en && !sub_osc_en, "R8 enables off in halt", {main_osc_en, sub_osc_en}, 0);
    chk(!main_stable && !sub_stable, "R11 flags cleared in halt", {main_stable, sub_stable}, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_ref);
      if (!phi_cpu || !phi_per) high = 1'b0;
    end
    chk(high, "R8 both phases high in halt", high, 1);
    @(negedge clk_ref); wake_irq = 1'b1;
    @(negedge clk_ref); wake_irq = 1'b0;
    chk(main_osc_en && sub_osc_en, "R10 enables back after halt wake", {main_osc_en, sub_osc_en}, 3);
    high = 1'b1;
    while (!main_stable && guard < 200) begin
      if (!phi_cpu) high = 1'b0;
      @(negedge clk_ref); guard++;
    end
    chk(high, "R10 phase held until source stable", high, 1);
    chk(main_stable && !sub_stable, "R11 sub still unsettled at main settle", sub_stable, 0);
    measure(per, hi);
    chk(per == MID_PER, "R10 middle speed after halt wake", per, MID_PER);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_ref);
    rst_n = 1'b1;
    @(negedge clk_ref);
    t_reset();
    t_mid();
    t_high();
    t_switch();
    t_low();
    t_halt();
    t_guard();
    t_wait();
    t_stop();
    chk(runts == 0, "R12 no shortened processor low phase", runts, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule